// File: doc/BRIEF.md
# Complement-Checked Serial Number Scanner

This block finds a serial number kept in a reserved region of word storage. Each record in that region is a pair of words. The word at the even index is the candidate value. The word at the following odd index is a check word that must be the bitwise inverse of the candidate. After one start pulse, the block walks the region from its highest pair downward. It stops at the first pair that holds a consistent value/inverse record, which is the newest valid entry.

The block reaches the storage through a read port split into two streams. The request stream carries a word index. The response stream returns one 32-bit word per request. When the walk ends, a single-cycle done pulse appears. The serial output and the found flag then hold their result until the next accepted start. If no pair is consistent, the serial output carries the candidate of the last pair examined and the found flag stays low.

Back-pressure works as follows. A request is transferred on a clock edge where `rd_req_valid` and `rd_req_ready` are both high. While it waits, the block keeps `rd_req_valid` high and `rd_req_addr` unchanged. A response is transferred on an edge where `rd_rsp_valid` and `rd_rsp_ready` are both high. The block raises `rd_rsp_ready` only while exactly one request is outstanding. It never has more than one request in flight. The control pins `start`, `done` and `found` are plain levels and pulses.

Top module: `serial_scan`

## Requirements
- R1: After reset, `done`, `found` and `rd_req_valid` are low and `serial_out` is zero.
- R2: After an accepted start, the first request reads index 0xFE. Each pair is read candidate first (even index i), then check word (odd index i+1).
- R3: At most one request is outstanding. No new request is raised until the response to the previous one has been transferred.
- R4: Once `rd_req_valid` is raised, it stays high with a stable `rd_req_addr` until the request is transferred.
- R5: A pair whose candidate equals the bitwise inverse of its check word ends the scan. `serial_out` then equals that candidate and `found` is 1.
- R6: After an inconsistent pair the index drops by 2. The scan goes on only while the new index is above zero, so indices 0 and 1 are never requested.
- R7: If no pair from 0xFE down to 2 is consistent, `serial_out` equals the word at index 2 and `found` is 0.
- R8: Each accepted start produces exactly one `done` pulse, one cycle long. It comes the cycle after the final response is transferred, with `serial_out` and `found` already valid.
- R9: A start pulse that arrives while a scan is in progress is ignored. The request sequence and the result are unchanged.
- R10: `rd_rsp_ready` is high only while one request is outstanding. Response data counts only on a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan when idle |
| rd_req_valid | output | 1 | Read request present |
| rd_req_ready | input | 1 | Storage accepts the request |
| rd_req_addr | output | 12 | Word index to read |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_ready | output | 1 | Block accepts read data |
| rd_rsp_data | input | 32 | Word returned by storage |
| serial_out | output | 32 | Serial number result |
| found | output | 1 | A consistent pair ended the last scan |
| done | output | 1 | One-cycle pulse at end of scan |

## Verification
The bound checker checks the port-level rules on every cycle:
- the single outstanding request;
- request hold under back-pressure;
- the floor on requested indices;
- the candidate-before-check ordering;
- the one-cycle done pulse;
- the found flag rising only with done.

Some behaviours depend on memory contents, so only the bench scenarios can show them. These are which pair is selected, the fallback to the word at index 2, the masking of index 0, and the ignoring of a start during a scan. The bench checks them by comparing against a behavioural model of the walk, under varied ready and latency patterns.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ_CAND = 3'd1,
    ST_WAIT_CAND= 3'd2,
    ST_REQ_CHK  = 3'd3,
    ST_WAIT_CHK = 3'd4
  } scan_state_t;

  localparam int PAIR_STEP = 2;

endpackage

// File: rtl/scan_index.sv
module scan_index #(
  parameter int ADDR_W    = 12,
  parameter int TOP_INDEX = 'hFE,
  parameter int STEP      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step_down,
  output logic [ADDR_W-1:0] idx,
  output logic              last_pair
);

  localparam logic [ADDR_W-1:0] TOP_VAL  = ADDR_W'(TOP_INDEX);
  localparam logic [ADDR_W-1:0] STEP_VAL = ADDR_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (load) begin
      idx <= TOP_VAL;
    end else if (step_down) begin
      idx <= idx - STEP_VAL;
    end
  end

  // the walk continues only while (idx - STEP) > 0
  assign last_pair = (idx <= STEP_VAL);

endmodule

// File: rtl/pair_judge.sv
module pair_judge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] candidate,
  input  logic [DATA_W-1:0] check_word,
  output logic              consistent
);

  assign consistent = (candidate == ~check_word);

endmodule

// File: rtl/scan_result.sv
module scan_result #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              cap_found,
  input  logic [DATA_W-1:0] cap_value,
  output logic [DATA_W-1:0] value,
  output logic              found,
  output logic              done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      found <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        value <= cap_value;
        found <= cap_found;
      end else if (clear) begin
        found <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_scan.sv
module serial_scan #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int TOP_INDEX = 'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic [DATA_W-1:0] serial_out,
  output logic              found,
  output logic              done
);
  import scan_pkg::*;

  scan_state_t       state, state_nx;
  logic [DATA_W-1:0] cand_q;
  logic [ADDR_W-1:0] idx;
  logic              last_pair;
  logic              consistent;
  logic              req_fire, rsp_fire;
  logic              go, step_down, capture;

  assign req_fire = rd_req_valid && rd_req_ready;
  assign rsp_fire = rd_rsp_valid && rd_rsp_ready;
  assign go       = (state == ST_IDLE) && start;

  assign rd_req_valid = (state == ST_REQ_CAND) || (state == ST_REQ_CHK);
  assign rd_req_addr  = (state == ST_REQ_CHK) ? idx + ADDR_W'(1) : idx;
  assign rd_rsp_ready = (state == ST_WAIT_CAND) || (state == ST_WAIT_CHK);

  assign capture   = (state == ST_WAIT_CHK) && rsp_fire && (consistent || last_pair);
  assign step_down = (state == ST_WAIT_CHK) && rsp_fire && !consistent && !last_pair;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:      if (start)    state_nx = ST_REQ_CAND;
      ST_REQ_CAND:  if (req_fire) state_nx = ST_WAIT_CAND;
      ST_WAIT_CAND: if (rsp_fire) state_nx = ST_REQ_CHK;
      ST_REQ_CHK:   if (req_fire) state_nx = ST_WAIT_CHK;
      ST_WAIT_CHK:  if (rsp_fire) state_nx = capture ? ST_IDLE : ST_REQ_CAND;
      default:                    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cand_q <= '0;
    end else begin
      state <= state_nx;
      if ((state == ST_WAIT_CAND) && rsp_fire) cand_q <= rd_rsp_data;
    end
  end

  scan_index #(
    .ADDR_W   (ADDR_W),
    .TOP_INDEX(TOP_INDEX),
    .STEP     (PAIR_STEP)
  ) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .step_down(step_down),
    .idx      (idx),
    .last_pair(last_pair)
  );

  pair_judge #(.DATA_W(DATA_W)) u_judge (
    .candidate (cand_q),
    .check_word(rd_rsp_data),
    .consistent(consistent)
  );

  scan_result #(.DATA_W(DATA_W)) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .capture  (capture),
    .cap_found(consistent),
    .cap_value(cand_q),
    .value    (serial_out),
    .found    (found),
    .done     (done)
  );

endmodule

// File: rtl/serial_scan_chk.sv
module serial_scan_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic              found,
  input logic              done
);

  logic              outst;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst     <= 1'b0;
      last_addr <= '0;
    end else begin
      if (rd_req_valid && rd_req_ready) begin
        outst     <= 1'b1;
        last_addr <= rd_req_addr;
      end else if (rd_rsp_valid && rd_rsp_ready) begin
        outst <= 1'b0;
      end
    end
  end

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !outst);

  p_rsp_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> outst);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_index_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr >= ADDR_W'(2)));

  p_pair_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_addr[0]) |-> (last_addr == rd_req_addr - ADDR_W'(1)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_found_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> done);

endmodule

bind serial_scan serial_scan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid),
  .rd_rsp_ready(rd_rsp_ready),
  .found       (found),
  .done        (done)
);

// File: tb/serial_scan_test.sv
`timescale 1ns/1ps
module serial_scan_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [11:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic [31:0] serial_out;
  logic        found;
  logic        done;

  always #2 clk = ~clk;

  serial_scan uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .serial_out(serial_out), .found(found), .done(done)
  );

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mem [0:255];
  int          exp_addr[$];
  logic [31:0] exp_serial;
  bit          exp_found;
  bit          active = 0;
  int          done_cnt = 0;
  bit          pend = 0;
  bit          rsp_taken = 0;
  int          lat = 0;
  int          cyc = 0;
  int          rdy_mode = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic void fill_plain();
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  function automatic void make_valid(int k, logic [31:0] v);
    mem[k] = v;
    mem[k+1] = ~v;
  endfunction

  // behavioural walk of the region
  function automatic void build_model();
    int i;
    exp_addr.delete();
    exp_found = 0;
    exp_serial = '0;
    for (i = 'hFE; i > 0; i -= 2) begin
      exp_addr.push_back(i);
      exp_addr.push_back(i + 1);
      exp_serial = mem[i];
      if (mem[i] == ~mem[i+1]) begin
        exp_found = 1;
        break;
      end
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      // compare on every clock
      if (!active) begin
        chk(done == 1'b0, "R8", "done while idle", 32'(done), 0);
        chk(rd_req_valid == 1'b0, "R9", "request while idle", 32'(rd_req_valid), 0);
      end else if (exp_addr.size() > 0) begin
        chk(done == 1'b0, "R8", "early done", 32'(done), 0);
      end else if (done) begin
        chk(serial_out == exp_serial, exp_found ? "R5" : "R7", "serial", serial_out, exp_serial);
        chk(found == exp_found, exp_found ? "R5" : "R7", "found", 32'(found), 32'(exp_found));
        done_cnt++;
        active = 0;
      end
      // response side
      if (rsp_taken) begin
        rd_rsp_valid = 1'b0;
        rsp_taken = 0;
      end
      if (pend) begin
        if (lat > 0) lat--;
        else begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = rd_req_addr_q;
        end
      end
      if (rd_rsp_valid && rd_rsp_ready) begin
        rsp_taken = 1;
        pend = 0;
      end
      // request side
      case (rdy_mode)
        0: rd_req_ready = 1'b1;
        1: rd_req_ready = (cyc % 3) != 0;
        default: rd_req_ready = (cyc % 5) == 2;
      endcase
      if (rd_req_valid && rd_req_ready) begin
        if (exp_addr.size() == 0) begin
          chk(0, "R6", "unexpected request", 32'(rd_req_addr), 0);
        end else begin
          int e;
          e = exp_addr.pop_front();
          chk(rd_req_addr == 12'(e), "R2", "request index", 32'(rd_req_addr), 32'(e));
        end
        pend = 1;
        rd_req_addr_q = mem[rd_req_addr[7:0]];
        lat = (rdy_mode == 0) ? 0 : (cyc % 3);
      end
    end
  end

  logic [31:0] rd_req_addr_q = '0;

  task automatic run_scan(int mode, int busy_poke);
    build_model();
    rdy_mode = mode;
    done_cnt = 0;
    @(negedge clk);
    active = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busy_poke > 0) begin
      repeat (busy_poke) @(negedge clk);
      start = 1'b1;   // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (active) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R8", "done pulses per scan", 32'(done_cnt), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 0, "R1", "done at reset", 32'(done), 0);
    chk(found == 0, "R1", "found at reset", 32'(found), 0);
    chk(rd_req_valid == 0, "R1", "req at reset", 32'(rd_req_valid), 0);
    chk(serial_out == 0, "R1", "serial at reset", serial_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: newest pair valid
    fill_plain(); make_valid('hFE, 32'hCAFE_0001);
    run_scan(0, 0);
    // R5/R6: valid in the middle, two valid pairs -> highest wins
    fill_plain(); make_valid('h80, 32'h1111_2222); make_valid('h40, 32'h3333_4444);
    run_scan(1, 0);
    // R7: no valid pair
    fill_plain();
    run_scan(2, 0);
    // R6/R7: only index 0 valid, must be masked
    fill_plain(); make_valid(0, 32'h0BAD_F00D);
    run_scan(1, 0);
    // R5: lowest examined pair valid
    fill_plain(); make_valid(2, 32'h0000_0000);
    run_scan(0, 0);
    // R9: start while busy ignored
    fill_plain(); make_valid('hF0, 32'hDEAD_BEEF);
    run_scan(2, 7);
    // R3/R10: slow responses all the way down
    fill_plain(); make_valid('h10, 32'hFFFF_FFFF);
    run_scan(2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule